// File: doc/BRIEF.md
# Stack Processor ALU with Extended-Precision Results

This block is the arithmetic and logic unit of a small stack processor with a 32-bit data path. It receives the two top-of-stack operands, a short signed immediate taken from the instruction word, and an opcode. When the valid strobe is high, it loads the selected result into an output register.

Besides the usual bitwise and arithmetic operations, it offers reduction tests that return a full-width boolean (all ones or zero). This lets software feed a reduction result straight into a compare-and-branch.

Add, subtract and multiply each come in three forms:
- a low-word form;
- a signed high-word form;
- an unsigned high-word form.

Software combines these forms to build 64-bit and wider arithmetic out of 32-bit steps. The block flags any opcode outside its set for one cycle and loads zero in that case.

Top module: `stack_alu`

## Requirements
- R1: While `rstN` is low, `result` is 0 and `illegalOp` is 0.
- R2: Opcodes 0, 1 and 2 reduce `opA` with AND, OR and XOR over all bits. The result is 0xFFFFFFFF when the reduction is 1 and 0 when it is 0.
- R3: Opcodes 3, 4 and 5 give `opA & opB`, `opA | opB` and `opA ^ opB`. Opcode 6 gives `~opA`.
- R4: Opcode 7 gives `opA` plus `imm` sign-extended. `imm` is a 6-bit two's complement value from -32 to +31.
- R5: Opcode 8 gives the low 32 bits of `opA + opB`. Opcode 11 gives the low 32 bits of `opA - opB`.
- R6: Opcodes 9 and 10 give bits [63:32] of the 64-bit sum. Opcodes 12 and 13 give bits [63:32] of the 64-bit difference.
  - For opcodes 9 and 12, both operands are sign-extended.
  - For opcodes 10 and 13, both operands are zero-extended.
  - As a result, opcode 10 yields the carry (0 or 1), and opcode 13 yields 0xFFFFFFFF on borrow.
- R7: Opcode 14 gives the low 32 bits of `opA * opB`. Opcode 15 gives bits [63:32] of the signed product. Opcode 16 gives bits [63:32] of the unsigned product.
- R8: A result is loaded at the first rising edge at which `validIn` is high. While `validIn` is low, `result` holds its value whatever the other inputs do.
- R9: An opcode from 17 to 31 with `validIn` high loads 0 into `result` and raises `illegalOp` for exactly the following cycle. `illegalOp` is never high after a legal or absent operation.
- R10: `imm` affects only opcode 7, and `opB` is not used by opcodes 0, 1, 2, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| validIn | input | 1 | Operation strobe; loads the result register |
| opcode | input | 5 | Operation select (encoding in R2 to R9) |
| opA | input | 32 | First operand (next-to-top of stack) |
| opB | input | 32 | Second operand (top of stack) |
| imm | input | 6 | Signed immediate for add-immediate |
| result | output | 32 | Registered result |
| illegalOp | output | 1 | One-cycle flag for an unknown opcode |

## Verification
Every result, the illegal-op flag included, appears one clock edge after the cycle in which `validIn` is sampled high.

The bench drives inputs at the falling edge, lets the next rising edge capture them, and reads `result` and `illegalOp` at the falling edge that follows. It then drops `validIn` before it checks that the flag has cleared and that the result holds.

Expected values come from a reference function that redoes each operation with explicit 64-bit sign or zero extension. It is applied both to a fixed vector table and to generated operand patterns across all seventeen opcodes.

// File: rtl/stack_alu_pkg.sv
package stack_alu_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_RAND   = 5'd0,
    OP_ROR    = 5'd1,
    OP_RXOR   = 5'd2,
    OP_AND    = 5'd3,
    OP_OR     = 5'd4,
    OP_XOR    = 5'd5,
    OP_NOT    = 5'd6,
    OP_ADDI   = 5'd7,
    OP_ADD    = 5'd8,
    OP_ADD_SX = 5'd9,
    OP_ADD_UX = 5'd10,
    OP_SUB    = 5'd11,
    OP_SUB_SX = 5'd12,
    OP_SUB_UX = 5'd13,
    OP_MUL    = 5'd14,
    OP_MUL_SX = 5'd15,
    OP_MUL_UX = 5'd16
  } aluOp_e;

  localparam logic [OP_W-1:0] LAST_LEGAL_OP = 5'd16;

  typedef enum logic [3:0] {
    SEL_ZERO,
    SEL_RAND,
    SEL_ROR,
    SEL_RXOR,
    SEL_AND,
    SEL_OR,
    SEL_XOR,
    SEL_NOT,
    SEL_ADD_LO,
    SEL_ADD_HI,
    SEL_MUL_LO,
    SEL_MUL_HI
  } resSel_e;

  // Strobes passed from decode to the datapath
  typedef struct packed {
    resSel_e sel;
    logic    useImm;
    logic    doSub;
    logic    signExt;
    logic    load;
  } aluCtrl_t;

endpackage

// File: rtl/stack_alu_ctrl.sv
module stack_alu_ctrl
  import stack_alu_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            validIn,
  input  logic [OP_W-1:0] opcode,
  output aluCtrl_t        ctrl,
  output logic            illegalOp
);

  logic unknownOp;

  always_comb begin
    ctrl.sel     = SEL_ZERO;
    ctrl.useImm  = 1'b0;
    ctrl.doSub   = 1'b0;
    ctrl.signExt = 1'b0;
    ctrl.load    = validIn;
    unknownOp    = 1'b0;
    case (opcode)
      OP_RAND:   ctrl.sel = SEL_RAND;
      OP_ROR:    ctrl.sel = SEL_ROR;
      OP_RXOR:   ctrl.sel = SEL_RXOR;
      OP_AND:    ctrl.sel = SEL_AND;
      OP_OR:     ctrl.sel = SEL_OR;
      OP_XOR:    ctrl.sel = SEL_XOR;
      OP_NOT:    ctrl.sel = SEL_NOT;
      OP_ADDI: begin
        ctrl.sel    = SEL_ADD_LO;
        ctrl.useImm = 1'b1;
      end
      OP_ADD:    ctrl.sel = SEL_ADD_LO;
      OP_ADD_SX: begin
        ctrl.sel     = SEL_ADD_HI;
        ctrl.signExt = 1'b1;
      end
      OP_ADD_UX: ctrl.sel = SEL_ADD_HI;
      OP_SUB: begin
        ctrl.sel   = SEL_ADD_LO;
        ctrl.doSub = 1'b1;
      end
      OP_SUB_SX: begin
        ctrl.sel     = SEL_ADD_HI;
        ctrl.doSub   = 1'b1;
        ctrl.signExt = 1'b1;
      end
      OP_SUB_UX: begin
        ctrl.sel   = SEL_ADD_HI;
        ctrl.doSub = 1'b1;
      end
      OP_MUL:    ctrl.sel = SEL_MUL_LO;
      OP_MUL_SX: begin
        ctrl.sel     = SEL_MUL_HI;
        ctrl.signExt = 1'b1;
      end
      OP_MUL_UX: ctrl.sel = SEL_MUL_HI;
      default:   unknownOp = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) illegalOp <= 1'b0;
    else       illegalOp <= validIn & unknownOp;
  end

endmodule

// File: rtl/stack_alu_dp.sv
module stack_alu_dp
  import stack_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] result
);

  localparam int EXT_W  = DATA_W + 2;   // room for carry and sign of a 64-bit view
  localparam int MUL_W  = DATA_W + 1;
  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W-1:0] bEff;
  logic              extBitA, extBitB;
  logic [EXT_W-1:0]  extA, extB, addB, sum;
  logic [DATA_W-1:0] addHi;
  logic signed [MUL_W-1:0]  mulA, mulB;
  logic signed [PROD_W-1:0] prod;
  logic [DATA_W-1:0] nextRes;

  // Second adder operand: immediate (sign-extended) or opB
  assign bEff = ctrl.useImm ? {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm} : opB;

  // One shared adder; two extension bits give the high word of the wide result
  assign extBitA = ctrl.signExt & opA[DATA_W-1];
  assign extBitB = ctrl.signExt & bEff[DATA_W-1];
  assign extA    = {{2{extBitA}}, opA};
  assign extB    = {{2{extBitB}}, bEff};
  assign addB    = ctrl.doSub ? ~extB : extB;
  assign sum     = extA + addB + EXT_W'(ctrl.doSub);
  assign addHi   = {{(DATA_W-2){sum[EXT_W-1]}}, sum[EXT_W-1:DATA_W]};

  // One signed multiplier; operands carry a sign or zero bit on top
  assign mulA = {extBitA, opA};
  assign mulB = {ctrl.signExt & opB[DATA_W-1], opB};
  assign prod = PROD_W'(mulA) * PROD_W'(mulB);

  always_comb begin
    case (ctrl.sel)
      SEL_RAND:   nextRes = {DATA_W{&opA}};
      SEL_ROR:    nextRes = {DATA_W{|opA}};
      SEL_RXOR:   nextRes = {DATA_W{^opA}};
      SEL_AND:    nextRes = opA & opB;
      SEL_OR:     nextRes = opA | opB;
      SEL_XOR:    nextRes = opA ^ opB;
      SEL_NOT:    nextRes = ~opA;
      SEL_ADD_LO: nextRes = sum[DATA_W-1:0];
      SEL_ADD_HI: nextRes = addHi;
      SEL_MUL_LO: nextRes = prod[DATA_W-1:0];
      SEL_MUL_HI: nextRes = prod[PROD_W-1:DATA_W];
      default:    nextRes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)         result <= '0;
    else if (ctrl.load) result <= nextRes;
  end

endmodule

// File: rtl/stack_alu.sv
module stack_alu
  import stack_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [OP_W-1:0]   opcode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] result,
  output logic              illegalOp
);

  aluCtrl_t ctrl;

  stack_alu_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .validIn   (validIn),
    .opcode    (opcode),
    .ctrl      (ctrl),
    .illegalOp (illegalOp)
  );

  stack_alu_dp #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .opA    (opA),
    .opB    (opB),
    .imm    (imm),
    .result (result)
  );

endmodule

// File: rtl/stack_alu_chk.sv
module stack_alu_chk
  import stack_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              validIn,
  input logic [OP_W-1:0]   opcode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [IMM_W-1:0]  imm,
  input logic [DATA_W-1:0] result,
  input logic              illegalOp
);

  logic isRed;
  assign isRed = (opcode == OP_RAND) || (opcode == OP_ROR) || (opcode == OP_RXOR);

  AST_RED_BOOL: assert property (@(posedge clk) disable iff (!rstN)
    validIn && isRed |=> (result == '0) || (result == '1)); // R2

  AST_NOT_A: assert property (@(posedge clk) disable iff (!rstN)
    validIn && (opcode == OP_NOT) |=> result == ~$past(opA)); // R3

  AST_CARRY_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    validIn && (opcode == OP_ADD_UX) |=> result <= DATA_W'(1)); // R6

  AST_SIGNED_HI_SUB: assert property (@(posedge clk) disable iff (!rstN)
    validIn && (opcode == OP_SUB_SX) |=> (result == '0) || (result == '1)); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> $stable(result)); // R8

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> result == '0); // R9

  AST_NO_FLAG_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    !validIn || (opcode <= LAST_LEGAL_OP) |=> !illegalOp); // R9

  AST_FLAG_UNKNOWN: assert property (@(posedge clk) disable iff (!rstN)
    validIn && (opcode > LAST_LEGAL_OP) |=> illegalOp); // R9

endmodule

bind stack_alu stack_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .validIn   (validIn),
  .opcode    (opcode),
  .opA       (opA),
  .opB       (opB),
  .imm       (imm),
  .result    (result),
  .illegalOp (illegalOp)
);

// File: tb/stack_alu_test.sv
`timescale 1ns/1ps
module stack_alu_test;

  localparam int VEC_W = 5 + 32 + 32 + 6 + 32;
  localparam int NVEC  = 26;

  // {opcode, opA, opB, imm, expected}
  localparam logic [VEC_W-1:0] VEC [NVEC] = '{
    {5'd0,  32'hFFFFFFFF, 32'h00000000, 6'h00, 32'hFFFFFFFF},
    {5'd0,  32'h00000001, 32'hFFFFFFFF, 6'h00, 32'h00000000},
    {5'd1,  32'h00000001, 32'h00000000, 6'h00, 32'hFFFFFFFF},
    {5'd1,  32'h00000000, 32'hFFFFFFFF, 6'h00, 32'h00000000},
    {5'd2,  32'hFFFFFFFF, 32'h00000000, 6'h00, 32'h00000000},
    {5'd2,  32'h00000001, 32'h00000000, 6'h00, 32'hFFFFFFFF},
    {5'd3,  32'h36C9A53C, 32'h5CA3C396, 6'h00, 32'h14818114},
    {5'd4,  32'h36C9A53C, 32'h5CA3C396, 6'h00, 32'h7EEBE7BE},
    {5'd5,  32'h36C9A53C, 32'h5CA3C396, 6'h00, 32'h6A6A66AA},
    {5'd6,  32'h36C9A53C, 32'h5CA3C396, 6'h00, 32'hC9365AC3},
    {5'd7,  32'hA53C36C9, 32'h12345678, 6'h20, 32'hA53C36A9},
    {5'd7,  32'hA53C36C9, 32'h12345678, 6'h1F, 32'hA53C36E8},
    {5'd8,  32'hA53C36C9, 32'h5CA3C396, 6'h00, 32'h01DFFA5F},
    {5'd9,  32'hA53C36C9, 32'h5CA3C396, 6'h00, 32'h00000000},
    {5'd10, 32'hA53C36C9, 32'h5CA3C396, 6'h00, 32'h00000001},
    {5'd11, 32'hA53C36C9, 32'h5CA3C396, 6'h00, 32'h48987333},
    {5'd12, 32'hA53C36C9, 32'h5CA3C396, 6'h00, 32'hFFFFFFFF},
    {5'd13, 32'hA53C36C9, 32'h5CA3C396, 6'h00, 32'h00000000},
    {5'd14, 32'hA53C36C9, 32'h5CA3C396, 6'h00, 32'hCCFE34C6},
    {5'd15, 32'hA53C36C9, 32'h5CA3C396, 6'h00, 32'hDF2793AE},
    {5'd16, 32'hA53C36C9, 32'h5CA3C396, 6'h00, 32'h3BCB5744},
    {5'd8,  32'h00000001, 32'h00000002, 6'h3F, 32'h00000003},
    {5'd13, 32'h00000000, 32'h00000001, 6'h00, 32'hFFFFFFFF},
    {5'd9,  32'h80000000, 32'h80000000, 6'h00, 32'hFFFFFFFF},
    {5'd10, 32'hFFFFFFFF, 32'hFFFFFFFF, 6'h00, 32'h00000001},
    {5'd6,  32'h00000000, 32'hFFFFFFFF, 6'h2A, 32'hFFFFFFFF}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [4:0]  opcode = '0;
  logic [31:0] opA = '0, opB = '0;
  logic [5:0]  imm = '0;
  logic [31:0] result;
  logic        illegalOp;

  int checks = 0;
  int fails  = 0;
  logic [31:0] rng = 32'h1F2E3D4C;

  always #2.5 clk = ~clk;

  stack_alu uut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .opcode(opcode),
    .opA(opA), .opB(opB), .imm(imm), .result(result), .illegalOp(illegalOp)
  );

  function automatic string reqOf(input logic [4:0] op);
    if (op <= 5'd2)       return "R2";
    else if (op <= 5'd6)  return "R3";
    else if (op == 5'd7)  return "R4";
    else if (op == 5'd8 || op == 5'd11) return "R5";
    else if (op <= 5'd13) return "R6";
    else if (op <= 5'd16) return "R7";
    else                  return "R9";
  endfunction

  // Behavioural reference built on explicit 64-bit extension
  function automatic logic [31:0] refAlu(input logic [4:0] op, input logic [31:0] a,
                                         input logic [31:0] b, input logic [5:0] im);
    logic [63:0] sa, sb, za, zb, w;
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    za = {32'h0, a};
    zb = {32'h0, b};
    case (op)
      5'd0:  return (a == 32'hFFFFFFFF) ? 32'hFFFFFFFF : 32'h0;
      5'd1:  return (a != 32'h0) ? 32'hFFFFFFFF : 32'h0;
      5'd2:  return (^a) ? 32'hFFFFFFFF : 32'h0;
      5'd3:  return a & b;
      5'd4:  return a | b;
      5'd5:  return a ^ b;
      5'd6:  return ~a;
      5'd7:  begin w = sa + {{58{im[5]}}, im}; return w[31:0]; end
      5'd8:  begin w = za + zb; return w[31:0]; end
      5'd9:  begin w = sa + sb; return w[63:32]; end
      5'd10: begin w = za + zb; return w[63:32]; end
      5'd11: begin w = za - zb; return w[31:0]; end
      5'd12: begin w = sa - sb; return w[63:32]; end
      5'd13: begin w = za - zb; return w[63:32]; end
      5'd14: begin w = za * zb; return w[31:0]; end
      5'd15: begin w = sa * sb; return w[63:32]; end
      5'd16: begin w = za * zb; return w[63:32]; end
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] nextRng(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check32(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check1(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Drive at the falling edge, capture at the rising edge, sample at the next falling edge
  task automatic doOp(input logic [4:0] op, input logic [31:0] a,
                      input logic [31:0] b, input logic [5:0] im);
    @(negedge clk);
    validIn = 1'b1; opcode = op; opA = a; opB = b; imm = im;
    @(negedge clk);
    validIn = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [31:0] a, b, keep;
    repeat (3) @(negedge clk);
    check32("R1", "result in reset", result, 32'h0);
    check1("R1", "illegalOp in reset", illegalOp, 1'b0);
    rstN = 1'b1;

    // Vector table (R10 rows: nonzero imm on add, opB/imm on NOT)
    for (int i = 0; i < NVEC; i++) begin
      logic [4:0] vOp;
      logic [31:0] vA, vB, vExp;
      logic [5:0] vImm;
      {vOp, vA, vB, vImm, vExp} = VEC[i];
      doOp(vOp, vA, vB, vImm);
      check32((i >= 21) ? "R10" : reqOf(vOp), $sformatf("table row %0d", i), result, vExp);
      check1("R9", "no flag on legal op", illegalOp, 1'b0);
    end

    // Generated operands across every legal opcode
    for (int n = 0; n < 170; n++) begin
      logic [4:0] gOp;
      logic [5:0] gImm;
      rng = nextRng(rng); a = rng;
      rng = nextRng(rng); b = rng;
      if (n % 5 == 0) b = 32'hFFFFFFFF - b[3:0];
      if (n % 7 == 0) a = {1'b1, 31'h0} | a[3:0];
      gOp = 5'(n % 17);
      gImm = rng[5:0];
      doOp(gOp, a, b, gImm);
      check32(reqOf(gOp), $sformatf("ref op %0d", gOp), result, refAlu(gOp, a, b, gImm));
    end

    // R8: hold while validIn low with moving inputs
    doOp(5'd8, 32'd100, 32'd23, 6'h0);
    keep = result;
    @(negedge clk);
    opcode = 5'd6; opA = 32'h5555AAAA; opB = 32'h1; imm = 6'h3;
    repeat (3) @(negedge clk);
    check32("R8", "hold while idle", result, keep);

    // R8: back-to-back operations, one per cycle
    @(negedge clk);
    validIn = 1'b1; opcode = 5'd3; opA = 32'hF0F0F0F0; opB = 32'hFF00FF00;
    @(negedge clk);
    check32("R8", "first of back-to-back", result, 32'hF000F000);
    opcode = 5'd11; opA = 32'd5; opB = 32'd7;
    @(negedge clk);
    check32("R8", "second of back-to-back", result, 32'hFFFFFFFE);
    validIn = 1'b0;

    // R9: unknown opcode, lowest and highest
    doOp(5'd17, 32'h12345678, 32'h9ABCDEF0, 6'h1);
    check32("R9", "result zero on opcode 17", result, 32'h0);
    check1("R9", "flag on opcode 17", illegalOp, 1'b1);
    @(negedge clk);
    check1("R9", "flag lasts one cycle", illegalOp, 1'b0);
    check32("R9", "zero held after flag", result, 32'h0);
    doOp(5'd7, 32'h1, 32'h0, 6'h2);
    check32("R4", "addi after illegal", result, 32'h3);
    doOp(5'd31, 32'hFFFFFFFF, 32'hFFFFFFFF, 6'h3F);
    check1("R9", "flag on opcode 31", illegalOp, 1'b1);
    check32("R9", "result zero on opcode 31", result, 32'h0);

    // R1: reset again clears state
    doOp(5'd6, 32'h0, 32'h0, 6'h0);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check32("R1", "result after second reset", result, 32'h0);
    rstN = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule